// File: doc/BRIEF.md
# Sequential Key Search Engine

This block walks a small on-chip table one entry per clock cycle, looking for a key. It reports the position of the lowest-numbered entry that holds the key, or reports that no such entry exists. Table contents are loaded through a simple write port into a register array. The scan reads that array combinationally, so one compare and one index step fit in a single cycle.

A search starts with a one-cycle `start` pulse. On that pulse the block captures the key and the table length and clears its index. This initialisation takes one cycle. Every entry it then probes costs exactly one more cycle. The end of a search is marked by a one-cycle `done` pulse. `found` and `match_idx` keep the outcome until the next search is accepted. A `start` that arrives while a scan is in progress is ignored.

Top module: `search_top`

## Requirements
- R1: While reset is high, and in the cycle after it, `done` and `found` are 0 and `match_idx` is 0.
- R2: If `start` is high in cycle c and the search probes n entries, `done` is high in cycle c+1+n and in no other cycle of that search.
- R3: On a hit, `found`=1 and `match_idx` is the lowest index below the effective length whose entry equals the key. The scan stops at that entry, so n = index+1.
- R4: On a miss, `found`=0 and `match_idx`=0. Every entry below the effective length is probed, so n = length.
- R5: A search with a length of 0 probes nothing. `done` is high one cycle after `start`, with `found`=0.
- R6: A length above DEPTH is treated as DEPTH, so the scan never probes an entry outside the table.
- R7: A `start` pulse that arrives while a scan is running changes neither the result nor the timing of that scan, and produces no extra `done`.
- R8: `done` is a single-cycle pulse. `found` and `match_idx` hold their value until the next accepted `start`, which clears them.
- R9: Entries at or above the effective length are never matched, even when they hold the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | IDX_W | Table write address |
| tbl_wdata | input | DATA_W | Table write data |
| start | input | 1 | Pulse that begins a search when idle |
| key | input | DATA_W | Value to look for, captured on an accepted start |
| tbl_len | input | LEN_W | Number of entries to scan, captured on an accepted start |
| done | output | 1 | One-cycle pulse when a search ends |
| found | output | 1 | High if the last search hit |
| match_idx | output | IDX_W | Index of the hit, 0 on a miss |

## Verification
The bench goes after first-match ordering: it loads duplicate keys. A design that kept scanning would report a later copy, or would take too long. It tests hits at index 0 and at the last entry, a length of 0, a length of 1, and a length above DEPTH. An off-by-one in the loop bound would show up here as one cycle too many or too few, or as a probe beyond the table. It places the key exactly at the length to catch a bound that includes the end. It also fires `start` in the middle of a scan. A design that restarted would return the second key's result, or a second `done`, and the bench would report either.

// File: rtl/search_pkg.sv
package search_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;

endpackage

// File: rtl/search_table.sv
module search_table #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  // Asynchronous read keeps compare and advance inside one cycle.
  assign rdata = mem_q[raddr];

endmodule

// File: rtl/search_ctrl.sv
module search_ctrl
  import search_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] key,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              accept,
  output logic              hit,
  output logic              exhaust
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);

  scan_state_t       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] key_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  len_eff;
  logic              last_entry;

  assign len_eff    = (len > LEN_MAX) ? LEN_MAX : len;
  assign accept     = (state_q == ST_IDLE) && start;
  assign rd_addr    = idx_q;
  assign last_entry = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;
  assign hit        = (state_q == ST_SCAN) && (rd_data == key_q);
  assign exhaust    = ((state_q == ST_SCAN) && !hit && last_entry) ||
                      (accept && (len_eff == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      key_q   <= '0;
      len_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            key_q <= key;
            len_q <= len_eff;
            idx_q <= '0;
            if (len_eff != '0) begin
              state_q <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (hit || last_entry) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: consecutive scan cycles advance the index by exactly one
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SCAN && $past(state_q) == ST_SCAN) |-> (idx_q == $past(idx_q) + IDX_W'(1)));

  // R6: every probed entry lies below the captured length, which is at most DEPTH
  assert_probe_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SCAN) |-> (LEN_W'(idx_q) < len_q && len_q <= LEN_MAX));

  // R7: a start during a scan leaves the captured key untouched
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SCAN && start) |=> $stable(key_q) && $stable(len_q));

endmodule

// File: rtl/search_result.sv
module search_result #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             hit,
  input  logic             exhaust,
  input  logic [IDX_W-1:0] idx,
  output logic             done,
  output logic             found,
  output logic [IDX_W-1:0] match_idx
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      found     <= 1'b0;
      match_idx <= '0;
    end else begin
      done <= hit || exhaust;
      if (accept) begin
        found     <= 1'b0;
        match_idx <= '0;
      end else if (hit) begin
        found     <= 1'b1;
        match_idx <= idx;
      end
    end
  end

  // R3: found only rises together with the end-of-search pulse
  assert_found_with_done_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> done);

  // R4: a finished miss reports index zero
  assert_miss_index_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> (match_idx == '0));

  // R8: result is held between searches unless a new one is accepted
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(accept) && !$past(hit)) |-> ($stable(found) && $stable(match_idx)));

endmodule

// File: rtl/search_top.sv
module search_top #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_waddr,
  input  logic [DATA_W-1:0] tbl_wdata,
  input  logic              start,
  input  logic [DATA_W-1:0] key,
  input  logic [LEN_W-1:0]  tbl_len,
  output logic              done,
  output logic              found,
  output logic [IDX_W-1:0]  match_idx
);

  logic [IDX_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              accept;
  logic              hit;
  logic              exhaust;

  search_table #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W)
  ) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  search_ctrl #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .LEN_W  (LEN_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .key     (key),
    .len     (tbl_len),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .accept  (accept),
    .hit     (hit),
    .exhaust (exhaust)
  );

  search_result #(
    .IDX_W (IDX_W)
  ) u_result (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .hit       (hit),
    .exhaust   (exhaust),
    .idx       (rd_addr),
    .done      (done),
    .found     (found),
    .match_idx (match_idx)
  );

  // R1: outputs are cleared in the cycle after reset is sampled
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!done && !found && match_idx == '0));

endmodule

// File: tb/search_top_bench.sv
`timescale 1ns/1ps
module search_top_bench;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 32;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LEN_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst;
  logic              tbl_we;
  logic [IDX_W-1:0]  tbl_waddr;
  logic [DATA_W-1:0] tbl_wdata;
  logic              start;
  logic [DATA_W-1:0] key;
  logic [LEN_W-1:0]  tbl_len;
  logic              done;
  logic              found;
  logic [IDX_W-1:0]  match_idx;

  always #2.5 clk = ~clk;

  search_top #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_search_top (
    .clk       (clk),
    .rst       (rst),
    .tbl_we    (tbl_we),
    .tbl_waddr (tbl_waddr),
    .tbl_wdata (tbl_wdata),
    .start     (start),
    .key       (key),
    .tbl_len   (tbl_len),
    .done      (done),
    .found     (found),
    .match_idx (match_idx)
  );

  typedef struct {
    bit    hit;
    int    idx;
    int    lat;
    string req;
  } exp_t;

  exp_t              sb_q[$];
  logic [DATA_W-1:0] shadow [DEPTH];
  int                cyc = 0;
  int                t0 = 0;
  int                n_checks = 0;
  int                n_fail = 0;
  bit                prev_done = 1'b0;
  bit                finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard whenever the block reports completion.
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) check(1'b0, "R8 done wider than one cycle", 1, 0);
      if (done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(found == e.hit, {e.req, " found"}, int'(found), int'(e.hit));
          check(int'(match_idx) == e.idx, {e.req, " match_idx"}, int'(match_idx), e.idx);
          check((cyc - t0) == e.lat, {e.req, " latency R2"}, cyc - t0, e.lat);
        end
      end
      prev_done = done;
    end
  end

  task automatic write_entry(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    tbl_we    = 1'b1;
    tbl_waddr = IDX_W'(a);
    tbl_wdata = d;
    shadow[a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  function automatic exp_t model(input logic [DATA_W-1:0] k, input int len, input string req);
    exp_t e;
    int   eff;
    eff   = (len > DEPTH) ? DEPTH : len;
    e.hit = 1'b0;
    e.idx = 0;
    e.lat = 1 + eff;
    e.req = req;
    for (int i = 0; i < eff; i++) begin
      if (shadow[i] == k) begin
        e.hit = 1'b1;
        e.idx = i;
        e.lat = 1 + i + 1;
        break;
      end
    end
    return e;
  endfunction

  task automatic pulse_start(input logic [DATA_W-1:0] k, input int len, input bit record);
    @(negedge clk);
    start   = 1'b1;
    key     = k;
    tbl_len = LEN_W'(len);
    if (record) t0 = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic search(input logic [DATA_W-1:0] k, input int len, input string req);
    sb_q.push_back(model(k, len, req));
    pulse_start(k, len, 1'b1);
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    logic [15:0] lfsr;
    rst       = 1'b1;
    tbl_we    = 1'b0;
    tbl_waddr = '0;
    tbl_wdata = '0;
    start     = 1'b0;
    key       = '0;
    tbl_len   = '0;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(found == 1'b0, "R1 found after reset", int'(found), 0);
    check(match_idx == '0, "R1 match_idx after reset", int'(match_idx), 0);

    for (int i = 0; i < DEPTH; i++) write_entry(i, DATA_W'(100 + 3 * i));

    search(DATA_W'(100 + 3 * 13), DEPTH, "R3 hit middle");
    search(DATA_W'(100), DEPTH, "R3 hit at index 0");
    search(DATA_W'(100 + 3 * 31), DEPTH, "R3 hit at last entry");
    search(DATA_W'(7), DEPTH, "R4 miss full table");
    search(DATA_W'(100), 0, "R5 zero length");
    search(DATA_W'(100), 1, "R3 length one hit");
    search(DATA_W'(103), 1, "R9 length one miss");
    search(DATA_W'(100 + 3 * 10), 10, "R9 key at the length");
    search(DATA_W'(100 + 3 * 31), 40, "R6 clamped length hit");
    search(DATA_W'(9), 63, "R6 clamped length miss");

    write_entry(20, DATA_W'(100 + 3 * 5));
    write_entry(27, DATA_W'(100 + 3 * 5));
    search(DATA_W'(100 + 3 * 5), DEPTH, "R3 first of duplicates");

    // R7: a second start in mid-scan must not disturb the first search
    sb_q.push_back(model(DATA_W'(100 + 3 * 25), DEPTH, "R7 busy start ignored"));
    pulse_start(DATA_W'(100 + 3 * 25), DEPTH, 1'b1);
    repeat (3) @(negedge clk);
    pulse_start(DATA_W'(100), 4, 1'b0);
    drain();
    repeat (40) @(negedge clk);
    // R8: result still held long after completion
    check(found == 1'b1, "R8 found held", int'(found), 1);
    check(int'(match_idx) == 25, "R8 match_idx held", int'(match_idx), 25);

    lfsr = 16'hACE1;
    for (int i = 0; i < DEPTH; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      write_entry(i, DATA_W'(lfsr[3:0]));
    end
    for (int t = 0; t < 24; t++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      search(DATA_W'(lfsr[4:0]), int'(lfsr[10:5]) % 36, "R3 R4 mixed pattern");
    end

    report();
  end

endmodule